// File: doc/BRIEF.md
# Register-List Stack Push/Pop Sequencer

This block carries out the compressed register-list stack instructions: push, pop, pop-and-return, and pop-and-return-with-zeroed-a0. A decoded request arrives as a variant code, a 4-bit cumulative register-list code, a 2-bit stack immediate, a register-width mode, a reduced-register-profile flag and the current stack pointer. The block checks the request and then works out the register count, the register size and the rounded frame size. It then walks the stack one word per memory transaction.

For a push it reads each selected register through a register-file read port and stores it. For a pop it loads each word and writes it to the register file through a write port. The highest-numbered register is moved first and the address steps down by one register size after each transfer. When the walk ends, the block writes the new stack pointer to x2 and reports it with a completion pulse. For the return variants it also presents a redirect to the restored return address. Fetch, instruction decode and the memory system are outside this block.

Top module: `stack_seq`

## Requirements
- R1: The list code selects registers cumulatively: code 4 selects x1 only; 5 adds x8; 6 adds x9; each code from 7 to 14 adds one more of x18..x25 in turn; 15 adds x26 and x27 together. The selected registers are transferred from the highest register number to the lowest.
- R2: A request with list code 0, 1, 2 or 3 is refused. `illegal` pulses for one cycle in the cycle after the request. `busy` stays low, and no memory request and no register write follow.
- R3: When `reducedRegs` is 1, list codes 7 to 15 are refused in the same way as R2. Codes 4 to 6 run normally.
- R4: The register size is 4 bytes when `wideMode` is 0 and 8 bytes when it is 1. In 4-byte mode, addresses, the stack pointer, store data and load data are truncated to their low 32 bits and zero-extended.
- R5: The stack adjustment is the register count times the register size, rounded up to a multiple of 16, plus 16 times `spImm`.
- R6: A push (`op`=0) stores with `memWrite`=1. The first address is sp minus the register size, and each later store is one register size lower. The store data is the `rdData` value returned for `rdIdx`, which is the register being stored.
- R7: A pop (`op`=1, 2 or 3) loads with `memWrite`=0. The first address is sp plus the adjustment minus the register size, and each later load is one register size lower. In the cycle that `memReady` accepts a load, `rfWe` writes `memRData` into that register.
- R8: In the completion cycle `doneValid` is 1, and `doneSp` and a register write to x2 both carry the new stack pointer: sp minus the adjustment for a push, sp plus the adjustment for a pop.
- R9: For `op`=3 only, a register write of zero to x10 occurs in the cycle between the last load and the completion cycle.
- R10: For `op`=2 and 3, `redirValid` is 1 in the completion cycle and `redirPc` equals the value loaded into x1. For `op`=0 and 1, `redirValid` stays 0.
- R11: `busy` is high from the cycle after an accepted request through the completion cycle. A memory request holds its address, direction and data until `memReady` is 1. `startValid` and the request inputs are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Request strobe, taken when idle |
| op | input | 2 | 0 push, 1 pop, 2 pop+return, 3 pop+return+zero a0 |
| rlistCode | input | 4 | Cumulative register-list code |
| spImm | input | 2 | Extra stack space in units of 16 bytes |
| wideMode | input | 1 | 1 selects 8-byte registers, 0 selects 4-byte registers |
| reducedRegs | input | 1 | Reduced register profile active |
| spIn | input | DATA_W | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| illegal | output | 1 | One-cycle refusal pulse |
| rdIdx | output | 5 | Register-file read index for stores |
| rdData | input | DATA_W | Register-file read data |
| memReqValid | output | 1 | Memory request valid |
| memWrite | output | 1 | 1 store, 0 load |
| memAddr | output | DATA_W | Request byte address |
| memWData | output | DATA_W | Store data |
| memReady | input | 1 | Request accepted; load data valid |
| memRData | input | DATA_W | Load data |
| rfWe | output | 1 | Register-file write enable |
| rfIdx | output | 5 | Register-file write index |
| rfWData | output | DATA_W | Register-file write data |
| doneValid | output | 1 | Completion pulse |
| doneSp | output | DATA_W | New stack pointer |
| redirValid | output | 1 | PC redirect request |
| redirPc | output | DATA_W | Redirect target |

## Verification
The bench builds the block with the default DATA_W of 64. This covers both 4-byte mode, where truncation of the upper word can be seen on every address and data bus, and 8-byte mode, where a full 13-register frame with the largest immediate gives a 160-byte adjustment. The memory model returns a value derived from each address, and the register-read model returns a value derived from each index. Every stored or restored word therefore shows which register and which slot it belonged to. Alternating ready stalls exercise request holding. The request inputs are changed while the block is busy, to show they are ignored.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [1:0] {
    OP_PUSH    = 2'd0,
    OP_POP     = 2'd1,
    OP_POPRET  = 2'd2,
    OP_POPRETZ = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_ZERO = 2'd2,
    ST_DONE = 2'd3
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic xfer;
    logic advance;
    logic zeroA0;
    logic finish;
  } ctl_s;

  localparam int unsigned IDX_W     = 5;
  localparam int unsigned CNT_W     = 4;
  localparam int unsigned ADJ_W     = 8;
  localparam logic [IDX_W-1:0] REG_RA = 5'd1;
  localparam logic [IDX_W-1:0] REG_SP = 5'd2;
  localparam logic [IDX_W-1:0] REG_A0 = 5'd10;

  function automatic logic [CNT_W-1:0] listCount(input logic [3:0] code);
    if (code < 4'd4)       return '0;
    else if (code == 4'hF) return 4'd13;
    else                   return code - 4'd3;
  endfunction

  // position 0 is the lowest selected register
  function automatic logic [IDX_W-1:0] posToReg(input logic [CNT_W-1:0] pos);
    case (pos)
      4'd0:    return REG_RA;
      4'd1:    return 5'd8;
      4'd2:    return 5'd9;
      default: return {1'b0, pos} + 5'd15;
    endcase
  endfunction

endpackage

// File: rtl/stack_seq_dp.sv
module stack_seq_dp
  import stack_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_s              ctl,
  input  logic [1:0]        op,
  input  logic [3:0]        rlistCode,
  input  logic [1:0]        spImm,
  input  logic              wideMode,
  input  logic              reducedRegs,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] rdData,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRData,
  output logic              legalIn,
  output logic              lastStep,
  output logic              retZero,
  output logic [IDX_W-1:0]  rdIdx,
  output logic              memReqValid,
  output logic              memWrite,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic              rfWe,
  output logic [IDX_W-1:0]  rfIdx,
  output logic [DATA_W-1:0] rfWData,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneSp,
  output logic              redirValid,
  output logic [DATA_W-1:0] redirPc
);

  localparam logic [DATA_W-1:0] MASK_NARROW = {{(DATA_W-32){1'b0}}, {32{1'b1}}};

  // request decode
  logic [CNT_W-1:0]  cntIn;
  logic [ADJ_W-1:0]  sizeIn, bytesIn, roundIn, adjIn;
  logic [DATA_W-1:0] maskIn, spMasked, sizeInW, adjInW;

  always_comb begin
    cntIn    = listCount(rlistCode);
    legalIn  = (cntIn != '0) && !(reducedRegs && rlistCode > 4'd6);
    sizeIn   = wideMode ? 8'd8 : 8'd4;
    bytesIn  = {4'd0, cntIn} * sizeIn;
    roundIn  = (bytesIn + 8'd15) & 8'hF0;
    adjIn    = roundIn + {2'd0, spImm, 4'd0};
    maskIn   = wideMode ? '1 : MASK_NARROW;
    spMasked = spIn & maskIn;
    sizeInW  = {{(DATA_W-ADJ_W){1'b0}}, sizeIn};
    adjInW   = {{(DATA_W-ADJ_W){1'b0}}, adjIn};
  end

  // sequence state
  op_e               opR;
  logic [CNT_W-1:0]  cntR, stepR;
  logic [DATA_W-1:0] maskR, sizeR, spR, adjR, addrR, raR;

  logic              isPop;
  logic [CNT_W-1:0]  posNow;
  logic [IDX_W-1:0]  regNow;
  logic [DATA_W-1:0] ldVal, newSp;

  always_comb begin
    isPop    = (opR != OP_PUSH);
    posNow   = cntR - 4'd1 - stepR;
    regNow   = posToReg(posNow);
    lastStep = (posNow == '0);
    retZero  = (opR == OP_POPRETZ);
    ldVal    = memRData & maskR;
    newSp    = (isPop ? spR + adjR : spR - adjR) & maskR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR   <= OP_PUSH;
      cntR  <= '0;
      stepR <= '0;
      maskR <= '0;
      sizeR <= '0;
      spR   <= '0;
      adjR  <= '0;
      addrR <= '0;
      raR   <= '0;
    end else if (ctl.capture) begin
      opR   <= op_e'(op);
      cntR  <= cntIn;
      stepR <= '0;
      maskR <= maskIn;
      sizeR <= sizeInW;
      spR   <= spMasked;
      adjR  <= adjInW;
      addrR <= ((op != 2'd0) ? spMasked + adjInW - sizeInW
                             : spMasked - sizeInW) & maskIn;
    end else if (ctl.advance) begin
      stepR <= stepR + 4'd1;
      addrR <= (addrR - sizeR) & maskR;
      if (isPop && lastStep) raR <= ldVal;
    end
  end

  // memory and register-file ports
  always_comb begin
    rdIdx       = regNow;
    memReqValid = ctl.xfer;
    memWrite    = ctl.xfer && !isPop;
    memAddr     = addrR;
    memWData    = isPop ? '0 : (rdData & maskR);
    rfWe        = 1'b0;
    rfIdx       = '0;
    rfWData     = '0;
    if (ctl.xfer && isPop && memReady) begin
      rfWe    = 1'b1;
      rfIdx   = regNow;
      rfWData = ldVal;
    end else if (ctl.zeroA0) begin
      rfWe    = 1'b1;
      rfIdx   = REG_A0;
    end else if (ctl.finish) begin
      rfWe    = 1'b1;
      rfIdx   = REG_SP;
      rfWData = newSp;
    end
    doneValid  = ctl.finish;
    doneSp     = ctl.finish ? newSp : '0;
    redirValid = ctl.finish && (opR == OP_POPRET || opR == OP_POPRETZ);
    redirPc    = redirValid ? raR : '0;
  end

endmodule

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic startValid,
  input  logic legalIn,
  input  logic lastStep,
  input  logic retZero,
  input  logic memReady,
  output ctl_s ctl,
  output logic busy,
  output logic illegal
);

  state_e state, stateNext;
  logic   illegalR;

  always_comb begin
    ctl         = '0;
    ctl.capture = (state == ST_IDLE) && startValid && legalIn;
    ctl.xfer    = (state == ST_XFER);
    ctl.advance = ctl.xfer && memReady;
    ctl.zeroA0  = (state == ST_ZERO);
    ctl.finish  = (state == ST_DONE);
    stateNext   = state;
    case (state)
      ST_IDLE: if (ctl.capture) stateNext = ST_XFER;
      ST_XFER: if (ctl.advance && lastStep) stateNext = retZero ? ST_ZERO : ST_DONE;
      ST_ZERO: stateNext = ST_DONE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      illegalR <= 1'b0;
    end else begin
      state    <= stateNext;
      illegalR <= (state == ST_IDLE) && startValid && !legalIn;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign illegal = illegalR;

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [1:0]        op,
  input  logic [3:0]        rlistCode,
  input  logic [1:0]        spImm,
  input  logic              wideMode,
  input  logic              reducedRegs,
  input  logic [DATA_W-1:0] spIn,
  output logic              busy,
  output logic              illegal,
  output logic [4:0]        rdIdx,
  input  logic [DATA_W-1:0] rdData,
  output logic              memReqValid,
  output logic              memWrite,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRData,
  output logic              rfWe,
  output logic [4:0]        rfIdx,
  output logic [DATA_W-1:0] rfWData,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneSp,
  output logic              redirValid,
  output logic [DATA_W-1:0] redirPc
);

  ctl_s ctl;
  logic legalIn, lastStep, retZero;

  stack_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .legalIn    (legalIn),
    .lastStep   (lastStep),
    .retZero    (retZero),
    .memReady   (memReady),
    .ctl        (ctl),
    .busy       (busy),
    .illegal    (illegal)
  );

  stack_seq_dp #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .op          (op),
    .rlistCode   (rlistCode),
    .spImm       (spImm),
    .wideMode    (wideMode),
    .reducedRegs (reducedRegs),
    .spIn        (spIn),
    .rdData      (rdData),
    .memReady    (memReady),
    .memRData    (memRData),
    .legalIn     (legalIn),
    .lastStep    (lastStep),
    .retZero     (retZero),
    .rdIdx       (rdIdx),
    .memReqValid (memReqValid),
    .memWrite    (memWrite),
    .memAddr     (memAddr),
    .memWData    (memWData),
    .rfWe        (rfWe),
    .rfIdx       (rfIdx),
    .rfWData     (rfWData),
    .doneValid   (doneValid),
    .doneSp      (doneSp),
    .redirValid  (redirValid),
    .redirPc     (redirPc)
  );

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              illegal,
  input logic              memReqValid,
  input logic              memWrite,
  input logic [DATA_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWData,
  input logic              memReady,
  input logic              rfWe,
  input logic [4:0]        rfIdx,
  input logic [DATA_W-1:0] rfWData,
  input logic              doneValid,
  input logic [DATA_W-1:0] doneSp,
  input logic              redirValid
);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReady |=> memReqValid && $stable(memAddr)
                                 && $stable(memWrite) && $stable(memWData));

  p_req_in_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy);

  p_illegal_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !busy && !memReqValid && !rfWe);

  p_push_no_rf_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memWrite |-> !rfWe);

  p_done_sp_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> rfWe && rfIdx == 5'd2 && rfWData == doneSp && busy);

  p_redir_at_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |-> doneValid);

  p_done_ends_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !busy);

endmodule

bind stack_seq stack_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .illegal     (illegal),
  .memReqValid (memReqValid),
  .memWrite    (memWrite),
  .memAddr     (memAddr),
  .memWData    (memWData),
  .memReady    (memReady),
  .rfWe        (rfWe),
  .rfIdx       (rfIdx),
  .rfWData     (rfWData),
  .doneValid   (doneValid),
  .doneSp      (doneSp),
  .redirValid  (redirValid)
);

// File: tb/test_stack_seq.sv
`timescale 1ns/1ps
module test_stack_seq;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic [1:0] op = '0;
  logic [3:0] rlistCode = '0;
  logic [1:0] spImm = '0;
  logic wideMode = 1'b0, reducedRegs = 1'b0;
  logic [DW-1:0] spIn = '0;
  logic busy, illegal, memReqValid, memWrite, rfWe, doneValid, redirValid;
  logic [4:0] rdIdx, rfIdx;
  logic [DW-1:0] rdData, memAddr, memWData, memRData, rfWData, doneSp, redirPc;
  logic memReady = 1'b0;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  always_comb rdData = {32'h1234_0000 | {27'd0, rdIdx}, 32'hCAFE_0000 | {27'd0, rdIdx}};
  always_comb memRData = {memAddr[31:0] ^ 32'hA5A5_0000, ~memAddr[31:0]};

  stack_seq i_stack_seq (.*);

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int tbCount(input int code);
    if (code < 4) return 0;
    if (code == 15) return 13;
    return code - 3;
  endfunction

  // k-th register in ascending order of the selected set
  function automatic logic [4:0] tbReg(input int k);
    logic [4:0] list [13] = '{5'd1, 5'd8, 5'd9, 5'd18, 5'd19, 5'd20, 5'd21,
                              5'd22, 5'd23, 5'd24, 5'd25, 5'd26, 5'd27};
    return list[k];
  endfunction

  function automatic logic [DW-1:0] msk(input logic [DW-1:0] v, input bit wide);
    return wide ? v : {32'd0, v[31:0]};
  endfunction

  task automatic runOp(input int opc, input int code, input int imm, input bit wide,
                       input bit red, input logic [DW-1:0] sp, input bit stall,
                       input string tag);
    int n = tbCount(code);
    int sz = wide ? 8 : 4;
    int adj = ((n * sz + 15) / 16) * 16 + imm * 16;
    logic [DW-1:0] base = msk(sp, wide);
    logic [DW-1:0] addr, expSp, raExp, expData;
    logic [4:0] reg_k;
    bit toggle = 1'b0;
    addr = (opc == 0) ? msk(base - DW'(sz), wide) : msk(base + DW'(adj) - DW'(sz), wide);
    expSp = (opc == 0) ? msk(base - DW'(adj), wide) : msk(base + DW'(adj), wide);
    raExp = '0;
    op = 2'(opc); rlistCode = 4'(code); spImm = 2'(imm);
    wideMode = wide; reducedRegs = red; spIn = sp; startValid = 1'b1;
    @(negedge clk);
    // R11: inputs scrambled and start held while busy must be ignored
    op = 2'd0; rlistCode = 4'd0; spImm = 2'd3; wideMode = ~wide; spIn = '0;
    check(busy == 1'b1, {tag, " R11 busy after accept"}, DW'(busy), 1);
    for (int k = 0; k < n; k++) begin
      reg_k = tbReg(n - 1 - k);
      if (stall) begin
        toggle = ~toggle;
        if (toggle) begin
          memReady = 1'b0;
          @(negedge clk);
        end
      end
      memReady = 1'b1;
      #0.5;
      if (opc == 0) begin
        expData = msk(rdData, wide);
        expData = msk({32'h1234_0000 | {27'd0, reg_k}, 32'hCAFE_0000 | {27'd0, reg_k}}, wide);
        check(memReqValid && memWrite && memAddr == addr && memWData == expData && !rfWe,
              {tag, " R6 store"}, memAddr ^ memWData, addr ^ expData);
      end else begin
        expData = msk({addr[31:0] ^ 32'hA5A5_0000, ~addr[31:0]}, wide);
        check(memReqValid && !memWrite && memAddr == addr && rfWe && rfIdx == reg_k
              && rfWData == expData, {tag, " R7 load"}, {memAddr[58:0], rfIdx},
              {addr[58:0], reg_k});
        if (reg_k == 5'd1) raExp = expData;
      end
      addr = msk(addr - DW'(sz), wide);
      @(negedge clk);
      memReady = 1'b0;
    end
    if (opc == 3) begin
      check(rfWe && rfIdx == 5'd10 && rfWData == '0 && !doneValid, {tag, " R9 zero a0"},
            {rfWData[58:0], rfIdx}, {59'd0, 5'd10});
      @(negedge clk);
    end
    check(doneValid && doneSp == expSp && rfWe && rfIdx == 5'd2 && rfWData == expSp,
          {tag, " R5 R8 new sp"}, doneSp, expSp);
    check(redirValid == (opc >= 2) && (opc < 2 || redirPc == raExp),
          {tag, " R10 redirect"}, redirPc, raExp);
    startValid = 1'b0;
    @(negedge clk);
    check(!busy && !illegal && !memReqValid, {tag, " R11 idle after done"}, DW'(busy), 0);
  endtask

  task automatic runIllegal(input int code, input bit red, input string tag);
    op = 2'd1; rlistCode = 4'(code); reducedRegs = red; wideMode = 1'b1;
    spIn = 64'h8000; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    check(illegal && !busy && !memReqValid && !rfWe, {tag, " refused"}, DW'(illegal), 1);
    @(negedge clk);
    check(!illegal && !busy && !memReqValid && !rfWe && !doneValid, {tag, " no side effect"},
          DW'(busy), 0);
  endtask

  task automatic tResetState();
    check(!busy && !illegal && !memReqValid && !rfWe && !doneValid && !redirValid,
          "R11 reset state", DW'(busy), 0);
  endtask

  task automatic tIllegalLow();  runIllegal(2, 1'b0, "R2 code2"); runIllegal(0, 1'b0, "R2 code0"); endtask
  task automatic tReduced();
    runIllegal(7, 1'b1, "R3 code7 reduced");
    runIllegal(15, 1'b1, "R3 code15 reduced");
    runOp(0, 6, 0, 1'b0, 1'b1, 64'h0000_0000_0000_1000, 1'b0, "R3 code6 reduced push");
  endtask
  task automatic tPushSmall();  runOp(0, 4, 0, 1'b0, 1'b0, 64'hFFFF_0000_0000_1000, 1'b0, "R1 R4 push ra rv32"); endtask
  task automatic tPushFull();   runOp(0, 15, 3, 1'b1, 1'b0, 64'h0000_0001_0000_2000, 1'b1, "R1 R4 push full rv64 stall"); endtask
  task automatic tPop();        runOp(1, 7, 1, 1'b0, 1'b0, 64'h0000_0000_0000_3000, 1'b0, "R7 pop rv32"); endtask
  task automatic tPopRet();     runOp(2, 5, 0, 1'b1, 1'b0, 64'h0000_0002_0000_4000, 1'b1, "R10 popret rv64"); endtask
  task automatic tPopRetZ();    runOp(3, 14, 2, 1'b0, 1'b0, 64'h0000_0000_0000_5000, 1'b1, "R9 popretz rv32 stall"); endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tIllegalLow();
    tReduced();
    tPushSmall();
    tPushFull();
    tPop();
    tPopRet();
    tPopRetZ();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule